// File: doc/BRIEF.md
# Core-Local Interrupt Arbiter

This block sits beside a single processor core and decides which interrupt the core should take next. It watches a parameterised set of raw request lines. For every line it keeps a pending flag, an enable flag, a trigger mode and an 8-bit control byte. A global split point divides each control byte into a preemption level and a priority within that level. Sources whose level does not exceed a global threshold are masked. The remaining enabled and pending sources compete on level, then priority, then source number. The winner is offered to the core when its level is strictly above the level of the handler now running.

The core answers with an acknowledge, which pushes the taken level onto a four-entry stack of active levels, and with a completion, which pops it. A completion leaves the block in a handover state. If an eligible request is waiting there, the block raises a tail-chain flag so that the core can start the next handler without first restoring the interrupted context. Software reaches the configuration through a synchronous write port and a combinational read port. The map has a split-point word at address 0, a read-only identity word at 1 and the threshold at 2. Source `i` sits at address `0x1000 + i`.

The handler state machine has three named states. `ST_IDLE` means no handler is active. `ST_ACTIVE` means at least one handler is on the stack. `ST_CHAIN` is the handover cycle after a completion. The transitions are as follows:
- IDLE to ACTIVE on an accepted acknowledge.
- ACTIVE to CHAIN on completion.
- ACTIVE stays ACTIVE on a nested acknowledge.
- CHAIN to ACTIVE on an accepted acknowledge, or when nothing is eligible and the stack is not empty.
- CHAIN to IDLE when nothing is eligible and the stack is empty.

Top module: `core_irq_arbiter`

## Requirements
- R1: After reset `irq_req` and `irq_tail` are 0, the split-point and threshold words read 0, and every source word reads `0x00000F00` (default parameters: disabled, level mode, implemented control bits 0).
- R2: The word at address 1 reads `{7'b0, CTLBITS[3:0], NSRC[12:0], 8'h01}`, and writes to it have no effect.
- R3: A source word reads `{16'b0, ctl[7:0], 4'b0, mode[1:0], enable, pending}`. Only the upper `CTLBITS` control bits store the written value; the lower control bits always read 1.
- R4: With split point `n` (word 0, bits [3:0], writes above 8 stored as 8), a source's level is `ctl | (8'hFF >> n)` and its priority is bits [15:8] of `{ctl, 8'hFF} << n`. `irq_lvl` shows the winner's level.
- R5: In mode 0 (level), and for the unused code 3, pending equals the input after two synchroniser flops. It becomes visible on the third rising clock edge after the input changes. Writing bit 0 of a source word never changes pending.
- R6: In mode 1 (rising), a 0-to-1 input transition sets pending. Pending then holds after the input falls, and it clears when the core acknowledges that source.
- R7: In mode 2 (falling), only a 1-to-0 transition sets pending, and an acknowledge of that source clears it.
- R8: Among pending, enabled, unmasked sources the winner has the highest level, then the highest priority, then the highest source number. `irq_id` carries it.
- R9: A source takes part only when its level is strictly greater than the threshold (word 2, bits [7:0]).
- R10: `irq_req` is high only when the winner's level is strictly above the active level (stack top, or 0 when the stack is empty) and the stack holds fewer than four entries. An accepted acknowledge pushes the winner's level.
- R11: `irq_done` in `ST_ACTIVE` pops the stack and enters `ST_CHAIN`. While in `ST_CHAIN`, `irq_tail` is high exactly when a request is eligible against the popped level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | AW | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| irq_in | input | NSRC | Raw interrupt request lines |
| irq_req | output | 1 | A request may be taken now |
| irq_id | output | IDW | Winning source number |
| irq_lvl | output | 8 | Winning source level |
| irq_tail | output | 1 | Tail-chain handover available |
| irq_ack | input | 1 | Core takes the offered request |
| irq_done | input | 1 | Core completes the running handler |

## Verification
The hardest situation to reach is a full stack of four nested handlers with a higher request still waiting. In that state a completion must turn the waiting request into a tail chain rather than a preemption. The bench gets there by raising rising-edge sources one at a time with climbing levels and acknowledging each, then raising a higher source and a lower source while the stack is full. It then walks the completions back down, so that the equal-level wait, the strictly-lower wait and the tail chain each occur at a known stack depth. The arbitration and threshold rules are swept exhaustively over every implemented control value in a sixteen-source setup.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

    typedef enum logic [1:0] {
        TRIG_LEVEL = 2'd0,
        TRIG_RISE  = 2'd1,
        TRIG_FALL  = 2'd2,
        TRIG_RSVD  = 2'd3
    } trig_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACTIVE = 2'd1,
        ST_CHAIN  = 2'd2
    } hst_e;

    localparam logic [7:0] HW_VERSION = 8'h01;

    // level: upper n bits of the control byte, unused low bits forced high
    function automatic logic [7:0] lvl_of(input logic [7:0] ctl, input logic [3:0] n);
        return ctl | (8'hFF >> n);
    endfunction

    // priority: bits below the level field, left-aligned, filled with ones
    function automatic logic [7:0] prio_of(input logic [7:0] ctl, input logic [3:0] n);
        logic [15:0] t;
        t = {ctl, 8'hFF} << n;
        return t[15:8];
    endfunction

endpackage

// File: rtl/irq_src_slot.sv
module irq_src_slot
    import irq_arb_pkg::*;
#(
    parameter int CTLBITS = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               raw,
    input  logic               wr_en,
    input  logic               w_en,
    input  logic [1:0]         w_mode,
    input  logic [CTLBITS-1:0] w_ctl,
    input  logic               ack_hit,
    output logic               pend,
    output logic               en,
    output trig_e              mode,
    output logic [7:0]         ctl
);
    localparam int LOB = 8 - CTLBITS;

    logic s1, s2, s3;
    logic rise, fall;
    logic [CTLBITS-1:0] ctl_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1 <= 1'b0;
            s2 <= 1'b0;
            s3 <= 1'b0;
        end else begin
            s1 <= raw;
            s2 <= s1;
            s3 <= s2;
        end
    end

    assign rise = s2 & ~s3;
    assign fall = ~s2 & s3;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend <= 1'b0;
        end else begin
            unique case (mode)
                TRIG_RISE: begin
                    if (rise)         pend <= 1'b1;
                    else if (ack_hit) pend <= 1'b0;
                end
                TRIG_FALL: begin
                    if (fall)         pend <= 1'b1;
                    else if (ack_hit) pend <= 1'b0;
                end
                default: pend <= s2;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en    <= 1'b0;
            mode  <= TRIG_LEVEL;
            ctl_q <= '0;
        end else if (wr_en) begin
            en    <= w_en;
            mode  <= trig_e'(w_mode);
            ctl_q <= w_ctl;
        end
    end

    generate
        if (LOB == 0) begin : g_full
            assign ctl = ctl_q;
        end else begin : g_part
            assign ctl = {ctl_q, {LOB{1'b1}}};
        end
    endgenerate

endmodule

// File: rtl/irq_arb_pick.sv
module irq_arb_pick #(
    parameter int NSRC = 16,
    parameter int IDW  = 4
) (
    input  logic [NSRC-1:0] cand,
    input  logic [7:0]      lvl  [NSRC],
    input  logic [7:0]      prio [NSRC],
    output logic            win_vld,
    output logic [IDW-1:0]  win_id,
    output logic [7:0]      win_lvl
);
    localparam int KW = 16 + IDW;

    logic [KW-1:0] key;
    logic [KW-1:0] best_key;
    logic [7:0]    unused_prio;

    // key ordering: level, then priority, then source number
    always_comb begin
        win_vld  = 1'b0;
        best_key = '0;
        key      = '0;
        for (int i = 0; i < NSRC; i++) begin
            key = {lvl[i], prio[i], IDW'(i)};
            if (cand[i] && (!win_vld || key > best_key)) begin
                best_key = key;
                win_vld  = 1'b1;
            end
        end
    end

    assign win_id      = best_key[IDW-1:0];
    assign win_lvl     = best_key[KW-1:IDW+8];
    assign unused_prio = best_key[IDW+7:IDW];

endmodule

// File: rtl/irq_level_stack.sv
module irq_level_stack #(
    parameter int DEPTH = 4,
    localparam int DW = $clog2(DEPTH + 1),
    localparam int PW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  logic [7:0]    push_lvl,
    output logic [7:0]    top_lvl,
    output logic [DW-1:0] depth
);
    logic [7:0]    mem [DEPTH];
    logic [DW-1:0] dm1;

    assign dm1 = depth - 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            depth <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (push && depth < DW'(DEPTH)) begin
            mem[depth[PW-1:0]] <= push_lvl;
            depth              <= depth + 1'b1;
        end else if (pop && depth != '0) begin
            depth <= dm1;
        end
    end

    assign top_lvl = (depth == '0) ? 8'd0 : mem[dm1[PW-1:0]];

endmodule

// File: rtl/core_irq_arbiter.sv
module core_irq_arbiter
    import irq_arb_pkg::*;
#(
    parameter int NSRC    = 16,
    parameter int CTLBITS = 4,
    parameter int DEPTH   = 4,
    parameter int AW      = 13,
    localparam int IDW = (NSRC > 1) ? $clog2(NSRC) : 1,
    localparam int DW  = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_we,
    input  logic [AW-1:0]   reg_addr,
    input  logic [15:0]     reg_wdata,
    output logic [31:0]     reg_rdata,
    input  logic [NSRC-1:0] irq_in,
    output logic            irq_req,
    output logic [IDW-1:0]  irq_id,
    output logic [7:0]      irq_lvl,
    output logic            irq_tail,
    input  logic            irq_ack,
    input  logic            irq_done
);
    localparam logic [AW-1:0] A_CFG  = AW'(0);
    localparam logic [AW-1:0] A_INFO = AW'(1);
    localparam logic [AW-1:0] A_THR  = AW'(2);

    logic [3:0]  nl_q;
    logic [7:0]  thr_q;
    logic        unused_wd;

    logic [NSRC-1:0] pend_w, en_w, cand, ack_hit;
    trig_e           mode_w [NSRC];
    logic [7:0]      ctl_w  [NSRC];
    logic [7:0]      lvl_w  [NSRC];
    logic [7:0]      prio_w [NSRC];
    logic [31:0]     word_w [NSRC];

    logic            win_vld;
    logic [IDW-1:0]  win_id;
    logic [7:0]      win_lvl;
    logic [7:0]      act_lvl;
    logic [DW-1:0]   depth;
    logic            eligible, take_ack, take_done;
    hst_e            st_q, st_d;

    assign unused_wd = ^reg_wdata;

    // global configuration words
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nl_q  <= 4'd0;
            thr_q <= 8'd0;
        end else if (reg_we) begin
            if (reg_addr == A_CFG)
                nl_q <= (reg_wdata[3:0] > 4'd8) ? 4'd8 : reg_wdata[3:0];
            if (reg_addr == A_THR)
                thr_q <= reg_wdata[7:0];
        end
    end

    // per-source state
    generate
        for (genvar i = 0; i < NSRC; i++) begin : g_src
            logic wr_i;
            assign wr_i = reg_we && reg_addr[AW-1] && (reg_addr[AW-2:0] == (AW-1)'(i));

            irq_src_slot #(.CTLBITS(CTLBITS)) u_slot (
                .clk     (clk),
                .rst_n   (rst_n),
                .raw     (irq_in[i]),
                .wr_en   (wr_i),
                .w_en    (reg_wdata[1]),
                .w_mode  (reg_wdata[3:2]),
                .w_ctl   (reg_wdata[15:16-CTLBITS]),
                .ack_hit (ack_hit[i]),
                .pend    (pend_w[i]),
                .en      (en_w[i]),
                .mode    (mode_w[i]),
                .ctl     (ctl_w[i])
            );

            assign lvl_w[i]   = lvl_of(ctl_w[i], nl_q);
            assign prio_w[i]  = prio_of(ctl_w[i], nl_q);
            assign cand[i]    = pend_w[i] && en_w[i] && (lvl_w[i] > thr_q);
            assign ack_hit[i] = take_ack && (win_id == IDW'(i));
            assign word_w[i]  = {16'd0, ctl_w[i], 4'd0, mode_w[i], en_w[i], pend_w[i]};
        end
    endgenerate

    irq_arb_pick #(.NSRC(NSRC), .IDW(IDW)) u_pick (
        .cand    (cand),
        .lvl     (lvl_w),
        .prio    (prio_w),
        .win_vld (win_vld),
        .win_id  (win_id),
        .win_lvl (win_lvl)
    );

    irq_level_stack #(.DEPTH(DEPTH)) u_stack (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (take_ack),
        .pop      (take_done),
        .push_lvl (win_lvl),
        .top_lvl  (act_lvl),
        .depth    (depth)
    );

    assign eligible  = win_vld && (win_lvl > act_lvl) && (depth < DW'(DEPTH));
    assign take_done = (st_q == ST_ACTIVE) && irq_done;
    assign take_ack  = eligible && irq_ack && !take_done;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (take_ack) st_d = ST_ACTIVE;
            end
            ST_ACTIVE: begin
                if (take_done) st_d = ST_CHAIN;
            end
            ST_CHAIN: begin
                if (take_ack)       st_d = ST_ACTIVE;
                else if (!eligible) st_d = (depth != '0) ? ST_ACTIVE : ST_IDLE;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        irq_req  = eligible;
        irq_tail = (st_q == ST_CHAIN) && eligible;
        irq_id   = win_id;
        irq_lvl  = win_lvl;
    end

    // register read
    always_comb begin
        reg_rdata = '0;
        if (reg_addr[AW-1]) begin
            for (int i = 0; i < NSRC; i++)
                if (reg_addr[AW-2:0] == (AW-1)'(i)) reg_rdata = word_w[i];
        end else if (reg_addr == A_CFG) begin
            reg_rdata = {28'd0, nl_q};
        end else if (reg_addr == A_INFO) begin
            reg_rdata = {7'd0, 4'(CTLBITS), 13'(NSRC), HW_VERSION};
        end else if (reg_addr == A_THR) begin
            reg_rdata = {24'd0, thr_q};
        end
    end

endmodule

// File: rtl/irq_arb_chk.sv
module irq_arb_chk
    import irq_arb_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int DW    = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          irq_req,
    input logic          irq_tail,
    input logic [7:0]    irq_lvl,
    input logic          irq_ack,
    input logic          irq_done,
    input logic [7:0]    thr_q,
    input logic [7:0]    act_lvl,
    input logic [DW-1:0] depth,
    input hst_e          st_q
);
    // R9
    req_above_thr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (irq_lvl > thr_q));

    // R10
    preempt_higher_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (irq_lvl > act_lvl));

    // R10
    depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        depth <= DW'(DEPTH));

    // R10
    ack_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && irq_ack && !(st_q == ST_ACTIVE && irq_done)) |=> (depth == $past(depth) + 1'b1));

    // R11
    done_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_ACTIVE && irq_done) |=> (depth == $past(depth) - 1'b1));

    // R11
    tail_has_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_tail |-> irq_req);

endmodule

bind core_irq_arbiter irq_arb_chk #(.DEPTH(DEPTH), .DW(DW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq_req  (irq_req),
    .irq_tail (irq_tail),
    .irq_lvl  (irq_lvl),
    .irq_ack  (irq_ack),
    .irq_done (irq_done),
    .thr_q    (thr_q),
    .act_lvl  (act_lvl),
    .depth    (depth),
    .st_q     (st_q)
);

// File: tb/test_core_irq_arbiter.sv
module test_core_irq_arbiter;
    localparam int NSRC = 16;
    localparam int CB   = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [12:0] reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [NSRC-1:0] irq_in = '0;
    logic        irq_req, irq_tail;
    logic [3:0]  irq_id;
    logic [7:0]  irq_lvl;
    logic        irq_ack = 1'b0;
    logic        irq_done = 1'b0;

    int nchk = 0;
    int nerr = 0;

    always #2 clk = ~clk;

    core_irq_arbiter #(.NSRC(NSRC), .CTLBITS(CB)) i_core_irq_arbiter (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_in(irq_in),
        .irq_req(irq_req), .irq_id(irq_id), .irq_lvl(irq_lvl),
        .irq_tail(irq_tail), .irq_ack(irq_ack), .irq_done(irq_done)
    );

    function automatic logic [7:0] b_ctl(input logic [7:0] v);
        return (v & (8'hFF << (8 - CB))) | (8'hFF >> CB);
    endfunction
    function automatic logic [7:0] b_lvl(input logic [7:0] c, input int n);
        return c | (8'hFF >> n);
    endfunction
    function automatic logic [7:0] b_prio(input logic [7:0] c, input int n);
        logic [15:0] t;
        t = {c, 8'hFF} << n;
        return t[15:8];
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    endtask

    task automatic wr(input logic [12:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [12:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic srcw(input int i, input logic en, input logic [1:0] md,
                        input logic [7:0] c, input logic pb);
        wr(13'(4096 + i), {c, 4'd0, md, en, pb});
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic ack();
        @(negedge clk); irq_ack = 1'b1;
        @(negedge clk); irq_ack = 1'b0;
    endtask

    task automatic done();
        @(negedge clk); irq_done = 1'b1;
        @(negedge clk); irq_done = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        logic [7:0] ca, cb2, la, lb, pa, pb;
        int expw;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 irq_req", 32'(irq_req), 32'd0);
        check("R1 irq_tail", 32'(irq_tail), 32'd0);
        rd(13'd0, d); check("R1 cfg", d, 32'd0);
        rd(13'd2, d); check("R1 thr", d, 32'd0);
        for (int i = 0; i < NSRC; i++) begin
            rd(13'(4096 + i), d); check("R1 src word", d, 32'h0000_0F00);
        end

        // R2 identity word
        rd(13'd1, d); check("R2 info", d, (32'(CB) << 21) | (32'(NSRC) << 8) | 32'h01);
        wr(13'd1, 16'hFFFF);
        rd(13'd1, d); check("R2 info read-only", d, (32'(CB) << 21) | (32'(NSRC) << 8) | 32'h01);

        // R3 control readback sweep
        for (int v = 0; v < 256; v++) begin
            srcw(3, 1'b0, 2'd0, 8'(v), 1'b0);
            rd(13'(4096 + 3), d);
            check("R3 ctl", d, {16'd0, b_ctl(8'(v)), 8'h00});
        end
        srcw(3, 1'b1, 2'd2, 8'hA0, 1'b0);
        rd(13'(4096 + 3), d); check("R3 fields", d, {16'd0, b_ctl(8'hA0), 8'h0A});
        srcw(3, 1'b0, 2'd0, 8'h00, 1'b0);

        // R4 level split sweep
        irq_in[5] = 1'b1;
        settle();
        for (int n = 0; n <= 8; n++) begin
            wr(13'd0, 16'(n));
            for (int u = 0; u < 16; u++) begin
                srcw(5, 1'b1, 2'd0, 8'(u << 4), 1'b0);
                check("R4 lvl", 32'(irq_lvl), 32'(b_lvl(b_ctl(8'(u << 4)), n)));
                check("R4 id", 32'(irq_id), 32'd5);
            end
        end
        wr(13'd0, 16'd13);
        rd(13'd0, d); check("R4 clamp", d, 32'd8);
        srcw(5, 1'b0, 2'd0, 8'h00, 1'b0);
        irq_in[5] = 1'b0;

        // R8 arbitration sweep with split point 2
        wr(13'd0, 16'd2);
        irq_in[2] = 1'b1; irq_in[9] = 1'b1;
        settle();
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                ca  = b_ctl(8'(a << 4));
                cb2 = b_ctl(8'(b << 4));
                srcw(2, 1'b1, 2'd0, 8'(a << 4), 1'b0);
                srcw(9, 1'b1, 2'd0, 8'(b << 4), 1'b0);
                la = b_lvl(ca, 2);  pa = b_prio(ca, 2);
                lb = b_lvl(cb2, 2); pb = b_prio(cb2, 2);
                expw = ((la > lb) || (la == lb && pa > pb)) ? 2 : 9;
                check("R8 winner", 32'(irq_id), 32'(expw));
            end
        end
        srcw(2, 1'b0, 2'd0, 8'h00, 1'b0);
        srcw(9, 1'b0, 2'd0, 8'h00, 1'b0);
        irq_in[2] = 1'b0; irq_in[9] = 1'b0;

        // R9 threshold sweep, level 0x7F
        wr(13'd0, 16'd8);
        irq_in[6] = 1'b1;
        srcw(6, 1'b1, 2'd0, 8'h70, 1'b0);
        settle();
        for (int t = 0; t < 256; t++) begin
            wr(13'd2, 16'(t));
            check("R9 mask", 32'(irq_req), (t < 8'h7F) ? 32'd1 : 32'd0);
        end
        wr(13'd2, 16'd0);
        srcw(6, 1'b0, 2'd0, 8'h00, 1'b0);
        irq_in[6] = 1'b0;

        // R5 level mode latency, read-only pending, code 3
        srcw(4, 1'b1, 2'd0, 8'h80, 1'b0);
        settle();
        @(negedge clk); irq_in[4] = 1'b1;
        repeat (2) @(negedge clk);
        rd(13'(4096 + 4), d); check("R5 not yet", 32'(d[0]), 32'd0);
        @(negedge clk);
        rd(13'(4096 + 4), d); check("R5 pending", 32'(d[0]), 32'd1);
        check("R5 req", 32'(irq_req), 32'd1);
        irq_in[4] = 1'b0;
        settle();
        rd(13'(4096 + 4), d); check("R5 follows low", 32'(d[0]), 32'd0);
        srcw(4, 1'b1, 2'd0, 8'h80, 1'b1);
        @(negedge clk);
        rd(13'(4096 + 4), d); check("R5 write ignored", 32'(d[0]), 32'd0);
        check("R5 no req", 32'(irq_req), 32'd0);
        srcw(4, 1'b1, 2'd3, 8'h80, 1'b0);
        irq_in[4] = 1'b1; settle();
        rd(13'(4096 + 4), d); check("R5 code3 high", 32'(d[0]), 32'd1);
        irq_in[4] = 1'b0; settle();
        rd(13'(4096 + 4), d); check("R5 code3 low", 32'(d[0]), 32'd0);
        srcw(4, 1'b0, 2'd0, 8'h00, 1'b0);

        // R6 rising edge
        srcw(7, 1'b1, 2'd1, 8'h90, 1'b0);
        irq_in[7] = 1'b1; settle();
        irq_in[7] = 1'b0; settle();
        rd(13'(4096 + 7), d); check("R6 held", 32'(d[0]), 32'd1);
        check("R6 id", 32'(irq_id), 32'd7);
        check("R6 req", 32'(irq_req), 32'd1);
        ack();
        rd(13'(4096 + 7), d); check("R6 ack clears", 32'(d[0]), 32'd0);
        check("R6 no req", 32'(irq_req), 32'd0);
        done(); settle();
        srcw(7, 1'b0, 2'd0, 8'h00, 1'b0);

        // R7 falling edge
        srcw(8, 1'b1, 2'd2, 8'h90, 1'b0);
        irq_in[8] = 1'b1; settle();
        rd(13'(4096 + 8), d); check("R7 rise ignored", 32'(d[0]), 32'd0);
        irq_in[8] = 1'b0; settle();
        rd(13'(4096 + 8), d); check("R7 fall sets", 32'(d[0]), 32'd1);
        check("R7 id", 32'(irq_id), 32'd8);
        ack();
        rd(13'(4096 + 8), d); check("R7 ack clears", 32'(d[0]), 32'd0);
        done(); settle();
        srcw(8, 1'b0, 2'd0, 8'h00, 1'b0);

        // R10 nesting to a full stack, R11 completion and tail chain
        for (int k = 0; k < 5; k++) srcw(10 + k, 1'b1, 2'd1, 8'((k + 1) << 4), 1'b0);
        srcw(15, 1'b1, 2'd1, 8'h20, 1'b0);
        for (int k = 0; k < 4; k++) begin
            irq_in[10 + k] = 1'b1; settle();
            check("R10 preempt req", 32'(irq_req), 32'd1);
            check("R10 preempt id", 32'(irq_id), 32'(10 + k));
            check("R10 preempt lvl", 32'(irq_lvl), 32'(((k + 1) << 4) | 15));
            ack();
            check("R10 taken", 32'(irq_req), 32'd0);
        end
        irq_in[14] = 1'b1; irq_in[15] = 1'b1; settle();
        check("R10 stack full", 32'(irq_req), 32'd0);
        done();
        check("R11 tail", 32'(irq_tail), 32'd1);
        check("R11 tail id", 32'(irq_id), 32'd14);
        ack();
        check("R11 after chain", 32'(irq_req), 32'd0);
        done();
        check("R11 lower waits", 32'(irq_tail), 32'd0);
        done();
        check("R10 equal waits", 32'(irq_req), 32'd0);
        check("R11 equal no tail", 32'(irq_tail), 32'd0);
        done();
        check("R11 tail lower", 32'(irq_tail), 32'd1);
        check("R11 tail lower id", 32'(irq_id), 32'd15);
        ack();
        done();
        check("R11 empty chain", 32'(irq_tail), 32'd0);
        done();
        check("R11 final tail", 32'(irq_tail), 32'd0);
        settle();
        check("R10 idle", 32'(irq_req), 32'd0);

        finish_run();
    end

endmodule